// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is the combinational arithmetic and logic unit of a 16-bit microcontroller datapath. It takes a destination operand, a source operand, a three-bit operation code, a byte/word select and the current carry. In the same cycle it returns a result, a write-back enable and four status flags: carry, zero, negative and overflow. The surrounding core registers these outputs. The decoder, the register file and operand fetch sit outside this block.

There are seven operations: add, add with carry, subtract, subtract with borrow, compare, AND and XOR. Subtraction is built as `dst + ~src + 1`. Subtract with borrow replaces the final `+1` with the incoming carry, so a set carry means that no borrow occurred. Compare runs the subtract path and reports its flags, but it lowers the write-back enable so that the destination keeps its value.

In byte mode only the low eight operand bits take part. Flags come from the 8-bit result, and the upper result byte is zero. The interface has no handshake: every output is a pure function of the present inputs.

Top module: `bw_alu`

## Requirements
- R1: Add (code 0) gives `dst + src` at the selected width, and carry_i has no effect on it. Add with carry (code 1) gives `dst + src + carry_i`. In both, c_o is the carry out of the selected width. Example: a byte add of 0x75 and 0xC7 gives 0x3C with c_o = 1.
- R2: Subtract (code 2) gives `dst + ~src + 1`. Subtract with borrow (code 3) gives `dst + ~src + carry_i`. c_o is the carry out of the selected width, so c_o = 1 means no borrow.
- R3: For codes 0 to 4, v_o is 1 exactly when the signed value of the true sum or difference lies outside the signed range of the selected width: -128..127 for bytes, -32768..32767 for words.
- R4: z_o is 1 exactly when the result at the selected width is zero.
- R5: n_o equals bit 7 of the result in byte mode and bit 15 in word mode.
- R6: Compare (code 4) produces the same res_o, c_o, z_o, n_o and v_o as subtract with the same operands, and wr_en_o = 0. Codes 0, 1, 2, 3, 5 and 6 set wr_en_o = 1.
- R7: AND (code 5) gives `dst & src`, with c_o = NOT z_o and v_o = 0.
- R8: XOR (code 6) gives `dst ^ src`, with c_o = NOT z_o. v_o is 1 exactly when both operands are negative at the selected width.
- R9: When byte_i = 1, res_o[15:8] is zero, and operand bits 15:8 have no effect on any output.
- R10: Code 7 is unused. It gives res_o = 0, wr_en_o = 0 and all four flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination operand (minuend for subtraction) |
| src_i | input | 16 | Source operand |
| op_i | input | 3 | Operation code: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 XOR, 7 unused |
| byte_i | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit operation |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result |
| wr_en_o | output | 1 | Write-back enable for the result |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |

## Verification
Carry and signed overflow can both come from one addition or subtraction. The bench provokes them together on purpose: it adds two large negative bytes, subtracts across the sign boundary at both widths, and runs a pseudo-random sweep. The bench judges each flag separately, against carry derived from unsigned arithmetic and overflow derived from signed integer arithmetic. Byte mode can also coincide with a wrap through zero. This is provoked by putting garbage in the upper operand bytes while the low bytes sum to zero. Z and the carry must then follow only the low byte.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBC = 3'd3,
    OP_CMP  = 3'd4,
    OP_AND  = 3'd5,
    OP_XOR  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/bw_alu_addsub.sv
module bw_alu_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             byte_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int HALF = WIDTH / 2;

  logic [HALF:0] lo_sum;
  logic [HALF:0] hi_sum;
  logic          a_sgn, b_sgn, r_sgn;

  // Two half-width lanes; the low lane carry feeds the high lane.
  assign lo_sum = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
  assign hi_sum = {1'b0, a_i[WIDTH-1:HALF]} + {1'b0, b_i[WIDTH-1:HALF]} + {{HALF{1'b0}}, lo_sum[HALF]};

  always_comb begin
    if (byte_i) begin
      sum_o  = {{(WIDTH-HALF){1'b0}}, lo_sum[HALF-1:0]};
      cout_o = lo_sum[HALF];
      a_sgn  = a_i[HALF-1];
      b_sgn  = b_i[HALF-1];
      r_sgn  = lo_sum[HALF-1];
    end else begin
      sum_o  = {hi_sum[HALF-1:0], lo_sum[HALF-1:0]};
      cout_o = hi_sum[HALF];
      a_sgn  = a_i[WIDTH-1];
      b_sgn  = b_i[WIDTH-1];
      r_sgn  = hi_sum[HALF-1];
    end
  end

  // b_i is already inverted for subtraction, so one rule covers both.
  assign ovf_o = (a_sgn == b_sgn) && (r_sgn != a_sgn);
endmodule

// File: rtl/bw_alu_logic.sv
module bw_alu_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             xor_i,
  input  logic             byte_i,
  output logic [WIDTH-1:0] res_o,
  output logic             both_neg_o
);
  localparam int HALF = WIDTH / 2;

  assign res_o      = xor_i ? (a_i ^ b_i) : (a_i & b_i);
  assign both_neg_o = byte_i ? (a_i[HALF-1] & b_i[HALF-1])
                             : (a_i[WIDTH-1] & b_i[WIDTH-1]);
endmodule

// File: rtl/bw_alu_zn.sv
module bw_alu_zn #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             byte_i,
  output logic             zero_o,
  output logic             neg_o
);
  localparam int HALF = WIDTH / 2;

  logic lo_zero, hi_zero;

  assign lo_zero = (res_i[HALF-1:0] == '0);
  assign hi_zero = (res_i[WIDTH-1:HALF] == '0);
  assign zero_o  = byte_i ? lo_zero : (lo_zero & hi_zero);
  assign neg_o   = byte_i ? res_i[HALF-1] : res_i[WIDTH-1];
endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] dst_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [2:0]       op_i,
  input  logic             byte_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wr_en_o,
  output logic             c_o,
  output logic             z_o,
  output logic             n_o,
  output logic             v_o
);
  localparam int HALF = WIDTH / 2;

  alu_op_e          op;
  logic [WIDTH-1:0] keep_mask;
  logic [WIDTH-1:0] a_op, b_op, b_arith;
  logic             is_sub, arith_cin;
  logic [WIDTH-1:0] sum, lres, sel_res;
  logic             sum_c, sum_v, both_neg;
  logic             zf, nf;
  alu_flags_t       fl;

  assign op        = alu_op_e'(op_i);
  assign keep_mask = byte_i ? {{(WIDTH-HALF){1'b0}}, {HALF{1'b1}}} : {WIDTH{1'b1}};
  assign a_op      = dst_i & keep_mask;
  assign b_op      = src_i & keep_mask;
  assign is_sub    = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign b_arith   = is_sub ? (~b_op & keep_mask) : b_op;

  always_comb begin
    unique case (op)
      OP_ADDC, OP_SUBC:    arith_cin = carry_i;
      OP_SUB, OP_CMP:      arith_cin = 1'b1;
      default:             arith_cin = 1'b0;
    endcase
  end

  bw_alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i    (a_op),
    .b_i    (b_arith),
    .cin_i  (arith_cin),
    .byte_i (byte_i),
    .sum_o  (sum),
    .cout_o (sum_c),
    .ovf_o  (sum_v)
  );

  bw_alu_logic #(.WIDTH(WIDTH)) i_logic (
    .a_i        (a_op),
    .b_i        (b_op),
    .xor_i      (op == OP_XOR),
    .byte_i     (byte_i),
    .res_o      (lres),
    .both_neg_o (both_neg)
  );

  always_comb begin
    unique case (op)
      OP_AND, OP_XOR: sel_res = lres;
      OP_NONE:        sel_res = '0;
      default:        sel_res = sum;
    endcase
  end

  bw_alu_zn #(.WIDTH(WIDTH)) i_zn (
    .res_i  (sel_res),
    .byte_i (byte_i),
    .zero_o (zf),
    .neg_o  (nf)
  );

  always_comb begin
    fl = '0;
    unique case (op)
      OP_AND:  fl = '{c: ~zf, z: zf, n: nf, v: 1'b0};
      OP_XOR:  fl = '{c: ~zf, z: zf, n: nf, v: both_neg};
      OP_NONE: fl = '0;
      default: fl = '{c: sum_c, z: zf, n: nf, v: sum_v};
    endcase
  end

  assign res_o   = sel_res;
  assign wr_en_o = (op != OP_CMP) && (op != OP_NONE);
  assign c_o     = fl.c;
  assign z_o     = fl.z;
  assign n_o     = fl.n;
  assign v_o     = fl.v;

  always_comb begin
    if (!$isunknown({op_i, byte_i, dst_i, src_i, carry_i})) begin
      if (byte_i)
        a_r9_upper_zero: assert (res_o[WIDTH-1:HALF] == '0)
          else $error("R9 upper byte not zero");
      if (op == OP_CMP)
        a_r6_cmp_no_wb: assert (!wr_en_o)
          else $error("R6 compare wrote back");
      if (op == OP_AND || op == OP_XOR)
        a_r7_logic_carry: assert (c_o == !z_o)
          else $error("R7 logic carry not inverse of zero");
      if (op == OP_AND)
        a_r7_and_no_overflow: assert (!v_o)
          else $error("R7 AND set overflow");
      if (op == OP_NONE)
        a_r10_unused_quiet: assert (!wr_en_o && res_o == '0 && !c_o && !z_o && !n_o && !v_o)
          else $error("R10 unused code not quiet");
      if (op == OP_ADD && !byte_i)
        a_r3_add_sign: assert (!v_o || (dst_i[WIDTH-1] == src_i[WIDTH-1] && n_o != dst_i[WIDTH-1]))
          else $error("R3 add overflow inconsistent with signs");
    end
  end
endmodule

// File: tb/test_bw_alu.sv
module test_bw_alu;
  logic [15:0] dst, src;
  logic [2:0]  op;
  logic        bsel, cin;
  logic [15:0] res;
  logic        wr, c, z, n, v;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bw_alu i_bw_alu (
    .dst_i(dst), .src_i(src), .op_i(op), .byte_i(bsel), .carry_i(cin),
    .res_o(res), .wr_en_o(wr), .c_o(c), .z_o(z), .n_o(n), .v_o(v)
  );

  // Independent model: unsigned for result/carry, signed ints for overflow.
  task automatic model(input logic [2:0] o, input logic b, input logic [15:0] d,
                       input logic [15:0] s, input logic ci,
                       output logic [15:0] er, output logic [4:0] ef);
    int w, mask, ua, ub, full, sa, sb, sr, lo, hi, r;
    logic ec, ez, en, ev, ew;
    w = b ? 8 : 16;
    mask = (1 << w) - 1;
    ua = int'(d) & mask;
    ub = int'(s) & mask;
    sa = (ua >= (1 << (w-1))) ? ua - (1 << w) : ua;
    sb = (ub >= (1 << (w-1))) ? ub - (1 << w) : ub;
    lo = -(1 << (w-1));
    hi = (1 << (w-1)) - 1;
    full = 0; sr = 0; r = 0; ec = 0; ev = 0; ew = 1;
    case (o)
      3'd0: begin full = ua + ub;                          sr = sa + sb; end
      3'd1: begin full = ua + ub + int'(ci);               sr = sa + sb + int'(ci); end
      3'd2, 3'd4: begin full = ua + ((~ub) & mask) + 1;    sr = sa - sb; end
      3'd3: begin full = ua + ((~ub) & mask) + int'(ci);   sr = sa - sb - 1 + int'(ci); end
      default: ;
    endcase
    if (o <= 3'd4) begin
      r  = full & mask;
      ec = ((full >> w) & 1) != 0;
      ev = (sr > hi) || (sr < lo);
    end else if (o == 3'd5 || o == 3'd6) begin
      r  = (o == 3'd5) ? (ua & ub) : (ua ^ ub);
      ec = (r != 0);
      ev = (o == 3'd6) && (sa < 0) && (sb < 0);
    end
    if (o == 3'd4 || o == 3'd7) ew = 0;
    ez = (r == 0);
    en = ((r >> (w-1)) & 1) != 0;
    if (o == 3'd7) begin r = 0; ez = 0; en = 0; end
    er = r[15:0];
    ef = {ew, ec, ez, en, ev};
  endtask

  task automatic apply(input string tag, input logic [2:0] o, input logic b,
                       input logic [15:0] d, input logic [15:0] s, input logic ci);
    logic [15:0] er;
    logic [4:0]  ef;
    @(negedge clk);
    op = o; bsel = b; dst = d; src = s; cin = ci;
    #2;
    model(o, b, d, s, ci, er, ef);
    n_vec++;
    if (res !== er || {wr, c, z, n, v} !== ef) begin
      n_bad++;
      $display("FAIL %s op=%0d byte=%0b dst=%h src=%h cin=%0b: res=%h wr,c,z,n,v=%b expected res=%h wr,c,z,n,v=%b",
               tag, o, b, d, s, ci, res, {wr, c, z, n, v}, er, ef);
    end
  endtask

  task automatic t_reset_state();
    apply("R4 reset-state all-zero add", 3'd0, 1'b0, 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_add();
    apply("R1 byte add 75+C7",            3'd0, 1'b1, 16'h0075, 16'h00C7, 1'b0);
    apply("R1 add ignores carry_i",       3'd0, 1'b0, 16'h1234, 16'h1111, 1'b1);
    apply("R1 addc uses carry_i",         3'd1, 1'b0, 16'h1234, 16'h1111, 1'b1);
    apply("R1 R4 word add wraps to zero", 3'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b0);
    apply("R3 R5 word add overflow",      3'd0, 1'b0, 16'h7FFF, 16'h0001, 1'b0);
    apply("R3 byte add carry+overflow",   3'd0, 1'b1, 16'h0080, 16'h0080, 1'b0);
  endtask

  task automatic t_sub();
    apply("R2 sub no borrow",             3'd2, 1'b0, 16'h0005, 16'h0003, 1'b0);
    apply("R2 R5 sub with borrow",        3'd2, 1'b0, 16'h0003, 16'h0005, 1'b1);
    apply("R2 subc carry clear",          3'd3, 1'b0, 16'h0005, 16'h0003, 1'b0);
    apply("R2 subc carry set",            3'd3, 1'b0, 16'h0005, 16'h0003, 1'b1);
    apply("R3 byte sub 80-01 overflow",   3'd2, 1'b1, 16'h0080, 16'h0001, 1'b0);
    apply("R3 word sub 8000-0001",        3'd2, 1'b0, 16'h8000, 16'h0001, 1'b0);
  endtask

  task automatic t_cmp();
    apply("R6 cmp equal",                 3'd4, 1'b0, 16'hA5A5, 16'hA5A5, 1'b0);
    apply("R6 cmp less",                  3'd4, 1'b1, 16'h0010, 16'h0020, 1'b1);
  endtask

  task automatic t_logic();
    apply("R7 and nonzero",               3'd5, 1'b0, 16'hF0F0, 16'h8F00, 1'b0);
    apply("R7 and zero",                  3'd5, 1'b0, 16'hF0F0, 16'h0F0F, 1'b1);
    apply("R8 xor both negative",         3'd6, 1'b0, 16'h8001, 16'hC000, 1'b0);
    apply("R8 xor equal gives zero",      3'd6, 1'b1, 16'h0099, 16'h0099, 1'b0);
    apply("R8 byte xor both negative",    3'd6, 1'b1, 16'h0081, 16'h00F0, 1'b0);
  endtask

  task automatic t_byte_mode();
    apply("R9 byte add junk upper to zero", 3'd0, 1'b1, 16'hAB01, 16'hCDFF, 1'b0);
    apply("R9 byte xor junk upper",         3'd6, 1'b1, 16'h7F12, 16'h8034, 1'b0);
    apply("R9 byte sub junk upper",         3'd2, 1'b1, 16'hFF00, 16'h0101, 1'b1);
  endtask

  task automatic t_unused();
    apply("R10 unused code",              3'd7, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1);
    apply("R10 unused code byte",         3'd7, 1'b1, 16'h0080, 16'h0080, 1'b0);
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ (lf << 7);
      apply("R1 R2 R3 R5 R6 R8 sweep", 3'(lf[2:0]), lf[3], lf[31:16], {lf[11:4], lf[27:20]}, lf[12]);
    end
  endtask

  initial begin
    op = 3'd0; bsel = 1'b0; dst = '0; src = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_byte_mode();
    t_unused();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired after %0d vectors", n_vec);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule